// File: doc/BRIEF.md
# Registered Two-Way Byte Transfer Unit with Parity and Ready Flags

This block moves bytes between two sides, A and B, through two independent registered paths. On the forward path an A-side byte is captured into a forward register, presented on the B side, and given a generated parity bit. On the return path a B-side byte is captured into a return register, and its accompanying parity bit is captured into a one-bit parity register. The byte is then presented on the A side, and the block flags a parity error when the stored byte and parity bit do not agree.

Each path has a ready flag. A capture sets it. The consumer clears it by releasing its output enable, which is a low-to-high change of the active-low enable. The whole block runs on one system clock. The capture strobes and the output enables are treated as asynchronous: each passes through a synchronizer, and its rising edge is found on the synchronized value. The pads that would be tri-state are modelled as a data output plus an active-high drive-enable output.

Top module: `dual_reg_xfer`

## Requirements
- R1: On a rising edge of `capClkAB` while `capEnAB_n` is LOW, the forward register takes the value of `aIn`. While `oeB_n` is LOW, that value appears on `bOut`.
- R2: A capture strobe edge with its active-low enable HIGH leaves the register of that path unchanged, on both paths.
- R3: A capture on a path sets that path's flag HIGH (`flagAB` for the forward path, `flagBA` for the return path). Each flag rises only after a capture made with the enable LOW.
- R4: A rising edge of `oeB_n` clears `flagAB`, and a rising edge of `oeA_n` clears `flagBA`. When a capture and a clearing edge fall in the same cycle on one path, the flag ends HIGH.
- R5: While `oeB_n` is LOW, `bDrive` is 1. While it is HIGH, `bDrive` is 0 and `bOut` reads all zeros. `aDrive` and `aOut` follow the same rule with `oeA_n`.
- R6: While `oeB_n` is LOW, `parOut` is 1 when the forward register holds an even count of ones (zero counts as even), `parOut` is 0 otherwise, and `parDrive` is 1. While `oeB_n` is HIGH, `parDrive` and `parOut` are 0.
- R7: On a rising edge of `capClkBA` while `capEnBA_n` is LOW, the return register takes `bIn` and the parity register takes `bParIn`. While `oeA_n` is LOW, the stored byte appears on `aOut`.
- R8: While `oeA_n` is LOW, `errOut` is 1 exactly when the return register and the parity register together hold an odd count of ones. While `oeA_n` is HIGH, `errOut` is 0.
- R9: A synchronous active-high `rst` clears both data registers, the parity register and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| aIn | input | WIDTH | A-side byte for the forward path |
| capClkAB | input | 1 | Forward capture strobe, acts on its rising edge |
| capEnAB_n | input | 1 | Forward capture enable, active low |
| oeB_n | input | 1 | B-side output enable, active low; its rising edge clears flagAB |
| bIn | input | WIDTH | B-side byte for the return path |
| bParIn | input | 1 | Parity bit that arrives with bIn |
| capClkBA | input | 1 | Return capture strobe, acts on its rising edge |
| capEnBA_n | input | 1 | Return capture enable, active low |
| oeA_n | input | 1 | A-side output enable, active low; its rising edge clears flagBA |
| bOut | output | WIDTH | B-side data, zero when not driven |
| bDrive | output | 1 | B-side drive enable |
| parOut | output | 1 | Generated parity for the forward register |
| parDrive | output | 1 | Drive enable for parOut |
| aOut | output | WIDTH | A-side data, zero when not driven |
| aDrive | output | 1 | A-side drive enable |
| errOut | output | 1 | Parity error for the return path |
| flagAB | output | 1 | Forward ready flag |
| flagBA | output | 1 | Return ready flag |

## Verification
The assertions assume that each capture enable and each data input is steady around the cycle in which a synchronized strobe edge causes a load, since these inputs are sampled directly with no synchronizer. The stimulus holds every strobe level for four system clocks and changes data and enables only while no strobe edge is in flight. It also holds both output enables HIGH during reset, so that a released enable never looks like a clearing edge.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;
  localparam int NUM_DIRS = 2;

  typedef struct packed {
    logic [NUM_DIRS-1:0] load;
    logic [NUM_DIRS-1:0] drive;
  } xferStrobe_t;
endpackage

// File: rtl/xfer_sync.sv
module xfer_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {CHAIN{RESET_VAL}};
    else     chain <= {chain[CHAIN-2:0], din};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_DIRS-1:0] capClk,
  input  logic [NUM_DIRS-1:0] capEn_n,
  input  logic [NUM_DIRS-1:0] oe_n,
  output xferStrobe_t         strobe,
  output logic [NUM_DIRS-1:0] flag
);
  logic [NUM_DIRS-1:0] capRise;
  logic [NUM_DIRS-1:0] capLevel;
  logic [NUM_DIRS-1:0] oeRise;
  logic [NUM_DIRS-1:0] oeLevel;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xfer_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_capSync (
      .clk(clk), .rst(rst), .din(capClk[d]),
      .level(capLevel[d]), .rise(capRise[d])
    );
    xfer_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_oeSync (
      .clk(clk), .rst(rst), .din(oe_n[d]),
      .level(oeLevel[d]), .rise(oeRise[d])
    );

    assign strobe.load[d]  = capRise[d] & ~capEn_n[d];
    assign strobe.drive[d] = ~oeLevel[d];

    // A load outranks a clearing edge arriving in the same cycle.
    always_ff @(posedge clk) begin
      if (rst)                 flag[d] <= 1'b0;
      else if (strobe.load[d]) flag[d] <= 1'b1;
      else if (oeRise[d])      flag[d] <= 1'b0;
    end
  end

  logic unusedLevels;
  assign unusedLevels = ^capLevel;
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  xferStrobe_t      strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             bParIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  output logic             parOut,
  output logic             parDrive,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive,
  output logic             errOut
);
  logic [WIDTH-1:0] fwdReg;
  logic [WIDTH-1:0] retReg;
  logic             retPar;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwdReg <= '0;
      retReg <= '0;
      retPar <= 1'b0;
    end else begin
      if (strobe.load[DIR_AB]) fwdReg <= aIn;
      if (strobe.load[DIR_BA]) begin
        retReg <= bIn;
        retPar <= bParIn;
      end
    end
  end

  assign bDrive   = strobe.drive[DIR_AB];
  assign bOut     = bDrive ? fwdReg : '0;
  assign parDrive = strobe.drive[DIR_AB];
  assign parOut   = parDrive & ~(^fwdReg);

  assign aDrive   = strobe.drive[DIR_BA];
  assign aOut     = aDrive ? retReg : '0;
  assign errOut   = aDrive & ((^retReg) ^ retPar);
endmodule

// File: rtl/dual_reg_xfer.sv
module dual_reg_xfer
  import xfer_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic             capClkAB,
  input  logic             capEnAB_n,
  input  logic             oeB_n,
  input  logic [WIDTH-1:0] bIn,
  input  logic             bParIn,
  input  logic             capClkBA,
  input  logic             capEnBA_n,
  input  logic             oeA_n,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  output logic             parOut,
  output logic             parDrive,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive,
  output logic             errOut,
  output logic             flagAB,
  output logic             flagBA
);
  xferStrobe_t         strobe;
  logic [NUM_DIRS-1:0] flag;

  xfer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst),
    .capClk({capClkBA, capClkAB}),
    .capEn_n({capEnBA_n, capEnAB_n}),
    .oe_n({oeA_n, oeB_n}),
    .strobe(strobe), .flag(flag)
  );

  xfer_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .aIn(aIn), .bIn(bIn), .bParIn(bParIn),
    .bOut(bOut), .bDrive(bDrive), .parOut(parOut), .parDrive(parDrive),
    .aOut(aOut), .aDrive(aDrive), .errOut(errOut)
  );

  assign flagAB = flag[DIR_AB];
  assign flagBA = flag[DIR_BA];
endmodule

// File: rtl/xfer_checker.sv
module xfer_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             capEnAB_n,
  input logic             capEnBA_n,
  input logic [WIDTH-1:0] bOut,
  input logic             bDrive,
  input logic             parOut,
  input logic             parDrive,
  input logic [WIDTH-1:0] aOut,
  input logic             aDrive,
  input logic             errOut,
  input logic             flagAB,
  input logic             flagBA
);
  assert_b_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !bDrive |-> (bOut == '0));
  assert_a_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !aDrive |-> (aOut == '0));
  assert_par_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    bDrive |-> (parDrive && (parOut == ~(^bOut))));
  assert_par_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !parDrive |-> !parOut);
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !aDrive |-> !errOut);
  assert_flagab_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flagAB) |-> !$past(capEnAB_n));
  assert_flagba_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flagBA) |-> !$past(capEnBA_n));
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!flagAB && !flagBA));
endmodule

bind dual_reg_xfer xfer_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .capEnAB_n(capEnAB_n), .capEnBA_n(capEnBA_n),
  .bOut(bOut), .bDrive(bDrive), .parOut(parOut), .parDrive(parDrive),
  .aOut(aOut), .aDrive(aDrive), .errOut(errOut),
  .flagAB(flagAB), .flagBA(flagBA)
);

// File: tb/sim_dual_reg_xfer.sv
`timescale 1ns/1ps
module sim_dual_reg_xfer;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic capClkAB = 0, capEnAB_n = 1, oeB_n = 1;
  logic capClkBA = 0, capEnBA_n = 1, oeA_n = 1, bParIn = 0;
  logic [W-1:0] bOut, aOut;
  logic bDrive, parOut, parDrive, aDrive, errOut, flagAB, flagBA;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_reg_xfer #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .aIn(aIn), .capClkAB(capClkAB), .capEnAB_n(capEnAB_n),
    .oeB_n(oeB_n), .bIn(bIn), .bParIn(bParIn), .capClkBA(capClkBA),
    .capEnBA_n(capEnBA_n), .oeA_n(oeA_n), .bOut(bOut), .bDrive(bDrive),
    .parOut(parOut), .parDrive(parDrive), .aOut(aOut), .aDrive(aDrive),
    .errOut(errOut), .flagAB(flagAB), .flagBA(flagBA)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 9; i++) n += (v >> i) & 1;
    return n;
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseAB();
    @(negedge clk) capClkAB = 1;
    waitN(4);
    capClkAB = 0;
    waitN(3);
  endtask

  task automatic pulseBA();
    @(negedge clk) capClkBA = 1;
    waitN(4);
    capClkBA = 0;
    waitN(3);
  endtask

  initial begin
    waitN(3);
    // Reset state with both enables released
    chk("R9 flagAB", flagAB, 0);
    chk("R9 flagBA", flagBA, 0);
    chk("R5 bDrive", bDrive, 0);
    chk("R5 aDrive", aDrive, 0);
    chk("R6 parDrive", parDrive, 0);
    rst = 0;
    waitN(2);

    // Capture with enable released: flag set, port undriven
    capEnAB_n = 0; aIn = 8'hC3;
    pulseAB();
    chk("R3 flagAB set", flagAB, 1);
    chk("R5 bOut idle", bOut, 0);
    chk("R6 parOut idle", parOut, 0);
    oeB_n = 0; waitN(4);
    chk("R5 bDrive on", bDrive, 1);
    chk("R1 bOut", bOut, 8'hC3);

    // Forward sweep over every byte
    for (int v = 0; v < 256; v++) begin
      aIn = v[W-1:0];
      pulseAB();
      chk("R1 sweep", bOut, v);
      chk("R6 sweep", parOut, (ones(v) % 2 == 0) ? 1 : 0);
    end

    // Held enable leaves forward register alone
    capEnAB_n = 1; aIn = 8'h5A;
    pulseAB();
    chk("R2 fwd hold", bOut, 8'hFF);

    // Release clears flag
    oeB_n = 1; waitN(4);
    chk("R4 flagAB clear", flagAB, 0);
    chk("R5 bOut off", bOut, 0);

    // Return path
    capEnBA_n = 0; oeA_n = 0;
    for (int v = 0; v < 512; v++) begin
      bIn = v[W-1:0]; bParIn = v[8];
      pulseBA();
      chk("R7 sweep", aOut, v & 8'hFF);
      chk("R8 sweep", errOut, ones(v) % 2);
    end
    chk("R3 flagBA set", flagBA, 1);
    // last value 0x1FF: odd total, error high
    capEnBA_n = 1; bIn = 8'h00; bParIn = 0;
    pulseBA();
    chk("R2 ret hold", aOut, 8'hFF);
    chk("R2 ret err hold", errOut, 1);
    oeA_n = 1; waitN(4);
    chk("R8 err gated", errOut, 0);
    chk("R4 flagBA clear", flagBA, 0);
    chk("R5 aOut off", aOut, 0);

    // Capture and release in the same cycle: set wins
    capEnAB_n = 0; aIn = 8'h11; oeB_n = 0; waitN(4);
    pulseAB();
    chk("R3 flagAB again", flagAB, 1);
    @(negedge clk) begin capClkAB = 1; oeB_n = 1; end
    waitN(4);
    capClkAB = 0;
    waitN(3);
    chk("R4 set wins", flagAB, 1);

    // Reset clears registers and flags
    capEnAB_n = 1;
    @(negedge clk) rst = 1;
    waitN(2);
    rst = 0;
    waitN(1);
    chk("R9 flagAB", flagAB, 0);
    chk("R9 flagBA", flagBA, 0);
    oeB_n = 0; oeA_n = 0; waitN(4);
    chk("R9 fwd zero", bOut, 0);
    chk("R9 ret zero", aOut, 0);
    chk("R9 parity of zero", parOut, 1);
    chk("R9 err zero", errOut, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule